// File: doc/BRIEF.md
# SPI Slave In-Band Interrupt Signaller

This block sits next to an SPI slave and lets it request the master's attention without a dedicated interrupt pin. It uses MISO itself as the interrupt line. Internal logic raises a request, and the block holds that request until it is cleared. When the master shows the bus is idle, the block pulls MISO low through an open-drain style output. Idle means MOSI is held high, SCK has not toggled for a set number of cycles, and this slave is not selected. At all other times the block leaves MISO at high impedance, and an external pull-up holds the line high.

Several slaves can share the line as a wired-AND, so the master polls each one to find which slave asked. The master lowers MOSI before it selects any device. The block treats a low MOSI as an order to let go of the line at once. A low MOSI and every SCK transition also restart the quiet timer. SCK, MOSI and the chip select each pass through a two-flop synchronizer inside the block.

Top module: `spi_inband_irq`

## Requirements
- R1: While reset is asserted and right after it, `miso_pull_o` and `pulling_o` are 0 and `miso_hiz_o` is 1.
- R2: `miso_pull_o` is 1 only when all of the following hold: a request is pending, the synchronized MOSI is high, the quiet timer has expired, and the chip select is deasserted. `pulling_o` always equals `miso_pull_o`, and `miso_hiz_o` is its complement.
- R3: Take a pending request with the chip select high and SCK steady. If MOSI rises on the pin before clock edge 1, `miso_pull_o` is still 0 after edge QUIET_CYC+1 and becomes 1 after edge QUIET_CYC+2.
- R4: A rising or a falling SCK transition on the pin releases the line after the second clock edge. The line stays released through edge QUIET_CYC+2 and is pulled again after edge QUIET_CYC+3.
- R5: When MOSI falls on the pin, the line stays pulled after the first clock edge and is released after the second.
- R6: A one-cycle pulse on `irq_req_i` is latched as a pending request, including a pulse that arrives while the bus is busy. A pulse on `irq_clr_i` drops the request, and the clear wins when both pulses arrive in the same cycle.
- R7: While `cs_n_i` is low (slave selected), the line is never pulled and the quiet timer is held at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master, asynchronous |
| mosi_i | input | 1 | Master data out, asynchronous; high signals idle |
| cs_n_i | input | 1 | This slave's chip select, active low |
| irq_req_i | input | 1 | Interrupt request pulse from internal logic |
| irq_clr_i | input | 1 | Clears the pending request |
| miso_pull_o | output | 1 | 1 drives MISO low |
| miso_hiz_o | output | 1 | 1 leaves MISO at high impedance as far as this block is concerned |
| pulling_o | output | 1 | Status: the line is being pulled low now |

## Verification
The bench builds the block with QUIET_CYC set to 8. With that value the exact edge counts for pulling and releasing can be checked directly: MOSI rising takes ten edges, an SCK transition takes eleven, and MOSI falling takes two. A whole quiet period also fits inside each row of the stimulus table, so each row can wait for its outputs to settle. With this small window, both SCK directions can be tested, and the timer restart caused by chip select shows up within a short run.

// File: rtl/spi_inband_irq.sv
module spi_inband_irq #(
  parameter int QUIET_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic cs_n_i,
  input  logic irq_req_i,
  input  logic irq_clr_i,
  output logic miso_pull_o,
  output logic miso_hiz_o,
  output logic pulling_o
);
  localparam int CW = $clog2(QUIET_CYC + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUIET_CYC);

  logic [1:0]    sck_sy, mosi_sy, csn_sy;
  logic          sck_q, pend_q;
  logic [CW-1:0] cnt_q;

  wire sck_s   = sck_sy[1];
  wire mosi_s  = mosi_sy[1];
  wire cs_n_s  = csn_sy[1];
  wire sck_evt = sck_s ^ sck_q;
  wire restart = ~mosi_s | sck_evt | ~cs_n_s;
  wire quiet   = (cnt_q == QMAX) & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= 2'b00;
      mosi_sy <= 2'b00;
      csn_sy  <= 2'b11;
      sck_q   <= 1'b0;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      csn_sy  <= {csn_sy[0], cs_n_i};
      sck_q   <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= '0;
    else if (cnt_q != QMAX)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (irq_clr_i) pend_q <= 1'b0;
    else if (irq_req_i) pend_q <= 1'b1;
  end

  assign miso_pull_o = pend_q & mosi_s & cs_n_s & quiet;
  assign miso_hiz_o  = ~miso_pull_o;
  assign pulling_o   = miso_pull_o;
endmodule

module spi_inband_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_req_i,
  input logic irq_clr_i,
  input logic mosi_s,
  input logic cs_n_s,
  input logic sck_evt,
  input logic pend_q,
  input logic miso_pull_o
);
  always @(posedge clk)
    if (!rst_n) p_reset_idle_r1: assert (!miso_pull_o);

  p_needs_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miso_pull_o |-> pend_q);
  p_rise_after_mosi_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_pull_o) |-> $past(mosi_s));
  p_sck_edge_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck_evt |-> !miso_pull_o);
  p_mosi_low_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mosi_s |-> !miso_pull_o);
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_i |=> !pend_q);
  p_req_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_i && !irq_clr_i) |=> pend_q);
  p_selected_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_s |-> !miso_pull_o);
endmodule

bind spi_inband_irq spi_inband_irq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .irq_clr_i(irq_clr_i),
  .mosi_s(mosi_s), .cs_n_s(cs_n_s), .sck_evt(sck_evt), .pend_q(pend_q),
  .miso_pull_o(miso_pull_o)
);

// File: tb/spi_inband_irq_tb_top.sv
module spi_inband_irq_tb_top;
  localparam int Q    = 8;
  localparam int HOLD = Q + 6;
  localparam int NV   = 13;
  // {sck, mosi, cs_n, req, clr, expected pull}
  localparam logic [5:0] VEC [NV] = '{
    6'b011000, 6'b011101, 6'b001000, 6'b011001, 6'b010000,
    6'b011001, 6'b011010, 6'b001100, 6'b011001, 6'b111001,
    6'b011110, 6'b011110, 6'b011101 };
  localparam int VREQ [NV] = '{2, 6, 5, 6, 7, 7, 6, 6, 6, 4, 6, 6, 6};

  logic clk = 0, rst_n = 0;
  logic sck = 0, mosi = 0, cs_n = 1, req = 0, clr = 0;
  logic pull, hiz, stat;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_inband_irq #(.QUIET_CYC(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .cs_n_i(cs_n),
    .irq_req_i(req), .irq_clr_i(clr), .miso_pull_o(pull),
    .miso_hiz_o(hiz), .pulling_o(stat));

  task automatic chk(input int r, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", r, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mosi = 1;
    edges(3);
    chk(1, pull, 1'b0, "pull in reset");
    chk(1, hiz, 1'b1, "hiz in reset");
    @(negedge clk) rst_n = 1;
    edges(2);
    chk(1, pull, 1'b0, "pull after reset");
    chk(1, stat, 1'b0, "status after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sck, mosi, cs_n, req, clr} = VEC[i][5:1];
      @(posedge clk);
      @(negedge clk);
      req = 0; clr = 0;
      edges(HOLD - 1);
      chk(VREQ[i], pull, VEC[i][0], $sformatf("row %0d pull", i));
      chk(2, hiz, ~VEC[i][0], $sformatf("row %0d hiz", i));
      chk(2, stat, VEC[i][0], $sformatf("row %0d status", i));
    end

    // R5: release two edges after MOSI falls
    @(negedge clk) mosi = 0;
    edges(1);
    chk(5, pull, 1'b1, "still pulled after edge 1");
    edges(1);
    chk(5, pull, 1'b0, "released after edge 2");
    edges(4);
    // R3: exact quiet window after MOSI rises
    @(negedge clk) mosi = 1;
    edges(Q + 1);
    chk(3, pull, 1'b0, "not yet at edge Q+1");
    edges(1);
    chk(3, pull, 1'b1, "pulled at edge Q+2");
    // R4: rising SCK
    @(negedge clk) sck = 1;
    edges(1);
    chk(4, pull, 1'b1, "rise: held at edge 1");
    edges(1);
    chk(4, pull, 1'b0, "rise: released at edge 2");
    edges(Q);
    chk(4, pull, 1'b0, "rise: still low at edge Q+2");
    edges(1);
    chk(4, pull, 1'b1, "rise: pulled at edge Q+3");
    // R4: falling SCK
    @(negedge clk) sck = 0;
    edges(2);
    chk(4, pull, 1'b0, "fall: released at edge 2");
    edges(Q + 1);
    chk(4, pull, 1'b1, "fall: pulled at edge Q+3");
    // R7: select then deselect restarts timer
    @(negedge clk) cs_n = 0;
    edges(2);
    chk(7, pull, 1'b0, "selected releases");
    @(negedge clk) cs_n = 1;
    edges(Q + 1);
    chk(7, pull, 1'b0, "timer restarted by select");
    edges(2);
    chk(7, pull, 1'b1, "pulled after window");
    // R1: reset in mid-pull
    @(negedge clk) rst_n = 0;
    #1;
    chk(1, pull, 1'b0, "reset releases");
    chk(1, hiz, 1'b1, "reset hiz");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule